// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the pending-interrupt flags of a 16-bit timer/counter and turns them into one interrupt request per source. There are five sources: counter overflow, three output-compare channels (A, B, C) and input capture. The counter, the comparators, the waveform logic and the mode decoder sit outside. They hand this block single-cycle event pulses and two mode bits. Each event is registered, so its flag appears on the clock edge that ends the event's cycle. A compare flag therefore shows up in the cycle after the counter matched.

Software reaches two 8-bit registers through a small read/write port. The flag register is cleared by writing ones. The enable register is a plain store. A flag is also cleared when the interrupt controller acknowledges that source's vector. A request is raised when the flag is set, the source is enabled and the global interrupt enable is high. If a hardware set meets a clear in the same cycle, the set wins, so no event is lost.

Top module: `timer_irq_flags`

## Requirements
- R1: While reset is asserted (rst_n low), every flag, every enable and every request is zero.
- R2: Register layout, with the same positions in both registers:
  - bit 0: overflow;
  - bits 1, 2 and 3: compare A, B and C;
  - bit 5: capture;
  - bits 4, 6 and 7: reserved. They always read zero and keep no written value.
  - reg_sel=0 selects the flag register and reg_sel=1 selects the enable register. reg_rdata is combinational from the selected register.
- R3: A pulse on cmp_match[i] (i=0 for A, 1 for B, 2 for C) sets that compare flag at the clock edge that ends the pulse's cycle. The flag is visible in the next cycle and not before.
- R4: A pulse on cmp_force[i] never sets any flag.
- R5: Writing the flag register clears every flag whose bit is written as one. Bits written as zero leave their flags unchanged.
- R6: A pulse on vec_ack[k] clears flag k. The index k, also used for irq, is: 0 overflow, 1 compare A, 2 compare B, 3 compare C, 4 capture.
- R7: The capture flag is set as follows:
  - with top_is_cap=0, by cap_evt;
  - with top_is_cap=1, by top_evt, and cap_evt is then ignored.
- R8: The overflow flag is set as follows:
  - with wrap_mode=1 (normal or clear-on-match counting), by wrap_evt;
  - with wrap_mode=0, by top_evt, and wrap_evt is then ignored.
- R9: When a set event and a clear (by write-one or by acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R10: irq[k] is high exactly when flag k is set, enable k is one and glb_ie is high. It follows the registers in the same cycle.
- R11: A write to the enable register stores bits 0-3 and 5 and leaves the flags untouched. A write to the flag register leaves the enables untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_match | input | N_CMP | Compare match pulses, index 0 = A |
| cmp_force | input | N_CMP | Forced-compare strobes (never set flags) |
| wrap_evt | input | 1 | Counter wrapped from its maximum |
| top_evt | input | 1 | Counter reached TOP |
| cap_evt | input | 1 | Capture event on the capture pin |
| wrap_mode | input | 1 | 1: overflow on wrap; 0: overflow on TOP |
| top_is_cap | input | 1 | 1: capture register serves as TOP |
| vec_ack | input | N_CMP+2 | Vector acknowledge pulses, per source |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: flag register, 1: enable register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register |
| glb_ie | input | 1 | Global interrupt enable |
| irq | output | N_CMP+2 | Interrupt request per source |

## Verification
The bench builds the block with its default parameters: three compare channels and an 8-bit register port. With these values the reserved bits fall exactly at positions 4, 6 and 7, so write-all-ones patterns can show that those bits neither read back nor linger. A table of one-cycle stimuli exercises both selections of each mode bit, in both directions for each event source. The table also combines set and clear events on the same flag, so that every table step is compared against a reference model of flags, enables and requests. Directed tests then pin the exact cycle in which a compare flag appears and check the state of every register during and after a mid-run reset.

// File: rtl/timer_irq_flags.sv
module timer_irq_flags #(
  parameter int N_CMP = 3,
  parameter int DW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CMP-1:0]   cmp_match,
  input  logic [N_CMP-1:0]   cmp_force,
  input  logic               wrap_evt,
  input  logic               top_evt,
  input  logic               cap_evt,
  input  logic               wrap_mode,
  input  logic               top_is_cap,
  input  logic [N_CMP+1:0]   vec_ack,
  input  logic               reg_we,
  input  logic               reg_sel,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic               glb_ie,
  output logic [N_CMP+1:0]   irq
);
  localparam int NSRC    = N_CMP + 2;
  localparam int CAP_BIT = N_CMP + 2;

  function automatic logic [NSRC-1:0] from_reg(input logic [DW-1:0] r);
    return {r[CAP_BIT], r[N_CMP:0]};
  endfunction

  function automatic logic [DW-1:0] to_reg(input logic [NSRC-1:0] s);
    logic [DW-1:0] r;
    r = '0;
    r[N_CMP:0] = s[N_CMP:0];
    r[CAP_BIT] = s[NSRC-1];
    return r;
  endfunction

  logic [NSRC-1:0] flags, en, set_vec, clr_vec;
  logic ovf_hit, cap_hit;

  assign ovf_hit = wrap_mode ? wrap_evt : top_evt;
  assign cap_hit = top_is_cap ? top_evt : cap_evt;
  assign set_vec = {cap_hit, cmp_match, ovf_hit};
  assign clr_vec = vec_ack | ((reg_we && !reg_sel) ? from_reg(reg_wdata) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
      if (reg_we && reg_sel) en <= from_reg(reg_wdata);
    end
  end

  assign reg_rdata = reg_sel ? to_reg(en) : to_reg(flags);
  assign irq       = glb_ie ? (flags & en) : '0;
endmodule

// File: rtl/timer_irq_flags_chk.sv
module timer_irq_flags_chk #(
  parameter int N_CMP = 3,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CMP-1:0] cmp_match,
  input logic [N_CMP-1:0] cmp_force,
  input logic [N_CMP+1:0] vec_ack,
  input logic             reg_we,
  input logic             reg_sel,
  input logic [DW-1:0]    reg_wdata,
  input logic [DW-1:0]    reg_rdata,
  input logic             glb_ie,
  input logic [N_CMP+1:0] irq,
  input logic [N_CMP+1:0] flags,
  input logic [N_CMP+1:0] en
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (flags == '0 && en == '0 && irq == '0));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[N_CMP+1] == 1'b0 && reg_rdata[DW-1:N_CMP+3] == '0);

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    assert_match_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_match[i] |=> flags[i+1]);
    assert_force_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_force[i] && !cmp_match[i] && !flags[i+1]) |=> !flags[i+1]);
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_ack[i+1] && !cmp_match[i]) |=> !flags[i+1]);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_match[i] && (vec_ack[i+1] || (reg_we && !reg_sel && reg_wdata[i+1]))) |=> flags[i+1]);
  end

  assert_zero_write_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel && reg_wdata == '0 && vec_ack == '0) |=> ((flags & $past(flags)) == $past(flags)));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~(flags & en)) == '0) && (glb_ie || irq == '0));
endmodule

bind timer_irq_flags timer_irq_flags_chk #(.N_CMP(N_CMP), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_match(cmp_match), .cmp_force(cmp_force),
  .vec_ack(vec_ack), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .glb_ie(glb_ie), .irq(irq), .flags(flags), .en(en)
);

// File: tb/test_timer_irq_flags.sv
module test_timer_irq_flags;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] cmp_match, cmp_force;
  logic wrap_evt, top_evt, cap_evt, wrap_mode, top_is_cap;
  logic [4:0] vec_ack;
  logic reg_we, reg_sel, glb_ie;
  logic [7:0] reg_wdata, reg_rdata;
  logic [4:0] irq;

  int total = 0, bad = 0;
  logic [7:0] mflags = '0, men = '0;

  always #5 clk = ~clk;

  timer_irq_flags i_timer_irq_flags (
    .clk(clk), .rst_n(rst_n), .cmp_match(cmp_match), .cmp_force(cmp_force),
    .wrap_evt(wrap_evt), .top_evt(top_evt), .cap_evt(cap_evt),
    .wrap_mode(wrap_mode), .top_is_cap(top_is_cap), .vec_ack(vec_ack),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .glb_ie(glb_ie), .irq(irq)
  );

  // fields: match, force, wrap, top, cap, wrap_mode, top_is_cap, ack, we, sel, wdata, gie
  localparam int NV = 18;
  localparam logic [26:0] VEC [NV] = '{
    {3'b000,3'b000,1'b0,1'b0,1'b0,1'b1,1'b0,5'b00000,1'b1,1'b1,8'hFF,1'b1}, // R11 R2 enables
    {3'b000,3'b111,1'b0,1'b0,1'b0,1'b1,1'b0,5'b00000,1'b0,1'b0,8'h00,1'b1}, // R4
    {3'b001,3'b000,1'b0,1'b0,1'b0,1'b1,1'b0,5'b00000,1'b0,1'b0,8'h00,1'b1}, // R3
    {3'b110,3'b001,1'b0,1'b0,1'b0,1'b1,1'b0,5'b00000,1'b0,1'b0,8'h00,1'b1}, // R3 R4
    {3'b000,3'b000,1'b0,1'b0,1'b0,1'b1,1'b0,5'b00000,1'b1,1'b0,8'h04,1'b1}, // R5
    {3'b000,3'b000,1'b0,1'b0,1'b0,1'b1,1'b0,5'b00000,1'b1,1'b0,8'h00,1'b1}, // R5
    {3'b000,3'b000,1'b0,1'b0,1'b0,1'b1,1'b0,5'b00010,1'b0,1'b0,8'h00,1'b1}, // R6
    {3'b000,3'b000,1'b1,1'b0,1'b0,1'b1,1'b0,5'b00000,1'b0,1'b0,8'h00,1'b1}, // R8
    {3'b000,3'b000,1'b1,1'b0,1'b0,1'b0,1'b0,5'b00000,1'b0,1'b0,8'h00,1'b1}, // R8
    {3'b000,3'b000,1'b0,1'b0,1'b0,1'b1,1'b0,5'b00000,1'b1,1'b0,8'hFF,1'b1}, // R5 R2
    {3'b000,3'b000,1'b1,1'b1,1'b0,1'b0,1'b0,5'b00000,1'b0,1'b0,8'h00,1'b1}, // R8 R7
    {3'b000,3'b000,1'b0,1'b0,1'b1,1'b1,1'b1,5'b00000,1'b0,1'b0,8'h00,1'b1}, // R7
    {3'b000,3'b000,1'b0,1'b1,1'b0,1'b1,1'b1,5'b00000,1'b0,1'b0,8'h00,1'b1}, // R7 R8
    {3'b000,3'b000,1'b0,1'b0,1'b1,1'b1,1'b0,5'b00000,1'b1,1'b0,8'h20,1'b1}, // R9
    {3'b000,3'b000,1'b0,1'b0,1'b1,1'b1,1'b0,5'b10000,1'b0,1'b0,8'h00,1'b1}, // R9 R6
    {3'b000,3'b000,1'b0,1'b0,1'b0,1'b1,1'b0,5'b00000,1'b0,1'b0,8'h00,1'b0}, // R10
    {3'b000,3'b000,1'b0,1'b0,1'b0,1'b1,1'b0,5'b00000,1'b1,1'b1,8'h03,1'b1}, // R11 R10
    {3'b100,3'b000,1'b0,1'b0,1'b0,1'b1,1'b0,5'b01000,1'b0,1'b0,8'h00,1'b1}  // R9
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cmp_match = '0; cmp_force = '0; wrap_evt = 0; top_evt = 0; cap_evt = 0;
    vec_ack = '0; reg_we = 0; reg_sel = 0; reg_wdata = '0;
  endtask

  task automatic verify_all(input string req);
    logic [7:0] e;
    reg_sel = 0; #1 check({req, " flags"}, reg_rdata, mflags);
    reg_sel = 1; #1 check({req, " enables"}, reg_rdata, men);
    e = glb_ie ? (mflags & men) : 8'h00;
    check({req, " irq"}, {3'b000, irq}, {3'b000, e[5], e[3:0]});
    reg_sel = 0;
  endtask

  task automatic run_vec(input logic [26:0] v);
    logic [7:0] setb, clrb, ackb;
    @(negedge clk);
    {cmp_match, cmp_force, wrap_evt, top_evt, cap_evt, wrap_mode, top_is_cap,
     vec_ack, reg_we, reg_sel, reg_wdata, glb_ie} = v;
    setb = {2'b00, (top_is_cap ? top_evt : cap_evt), 1'b0, cmp_match,
            (wrap_mode ? wrap_evt : top_evt)};
    ackb = {2'b00, vec_ack[4], 1'b0, vec_ack[3:0]};
    clrb = ackb | ((reg_we && !reg_sel) ? (reg_wdata & 8'h2F) : 8'h00);
    @(posedge clk);
    mflags = (mflags & ~clrb) | setb;
    if (reg_we && reg_sel) men = reg_wdata & 8'h2F;
    #1 idle();
    verify_all("R2/R3-R11 table");
  endtask

  initial begin
    #150000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    idle(); wrap_mode = 1; top_is_cap = 0; glb_ie = 0;
    #2 rst_n = 1'b0;
    #20;
    // R1: reset state
    verify_all("R1 reset");
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R3: exact cycle of a compare flag
    @(negedge clk); vec_ack = 5'b11111; @(negedge clk); idle();
    mflags = mflags & 8'hD0;
    cmp_match = 3'b010;
    #1 check("R3 not before edge", reg_rdata & 8'h04, 8'h00);
    @(posedge clk); #1 idle();
    check("R3 set after edge", reg_rdata & 8'h04, 8'h04);
    mflags = mflags | 8'h04;
    verify_all("R3 R10 after match");

    // R1: mid-run reset clears flags, enables and requests
    @(negedge clk); cmp_match = 3'b111; rst_n = 1'b0;
    #1 idle();
    mflags = '0; men = '0;
    verify_all("R1 mid-run reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    verify_all("R1 after release");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule